// File: doc/BRIEF.md
# Signature Sequence Watchdog Processor

This block checks the control flow of running software against a table of expected signatures. Software first fills the table while the block is idle. Each entry holds an expected signature value and a timeout in clock cycles. Software then sets the number of active entries and raises enable. From that point the block walks through the table in order. At every step an internal down-counter is loaded with that step's timeout, and the software has to write the matching signature before the counter runs out. When the last active entry has been accepted, the walk wraps back to entry 0.

A signature with the wrong value, or one that arrives out of order, trips the watchdog. So does a step whose counter runs out. A trip raises a non-maskable interrupt line and records the cause and the failing step index. Both stay asserted until software clears them. An external freeze input holds the counter so that it cannot time out. Signatures are still compared while freeze is high.

Top module: `sig_seq_wdog`

## Requirements
- R1: After reset, and while enable is low or the entry count is 0, the block stays idle. Signature writes in that state raise no interrupt.
- R2: Table writes and entry-count writes are accepted only while the block is idle. While it is running or tripped, these writes have no effect on the sequence that is checked.
- R3: On the rising edge where enable is first seen high in the idle state, step 0 starts and its counter is loaded with timeout T. A signature that equals the step's entry and is presented on any of the next T rising edges is accepted, and the walk moves to the next step with that step's timeout.
- R4: If no signature is presented on the T rising edges after a step starts, the block trips on the T-th edge with cause 2 (timeout) and the index of that step.
- R5: A presented signature that differs from the current step's entry trips the block on that edge with cause 1 (mismatch) and the current step index. This covers both a wrong value and an entry that belongs to another step.
- R6: After the entry at index count-1 is accepted, the next step is entry 0, with entry 0's timeout.
- R7: While freeze is high the counter holds its value and never times out. Signatures are still compared.
- R8: nmi_o is 1 exactly when the cause is not 0. It stays set until stat_clr_i is sampled high in the tripped state. The clear returns the block to idle with cause 0, and if enable is still high a new walk starts from entry 0.
- R9: Dropping enable while the block is running returns it to idle without a trip.
- R10: After reset, nmi_o, stat_cause_o and stat_idx_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write one table entry |
| cfg_idx_i | input | IDX_W | Entry index to write |
| cfg_sig_i | input | SIG_W | Expected signature for the entry |
| cfg_tmo_i | input | TMO_W | Timeout for the entry, in cycles (0 acts as 1) |
| cfg_len_we_i | input | 1 | Write the active entry count |
| cfg_len_i | input | CNT_W | Active entry count, clamped to DEPTH |
| cfg_en_i | input | 1 | Enable level |
| sig_valid_i | input | 1 | Signature write strobe |
| sig_i | input | SIG_W | Signature value |
| freeze_i | input | 1 | Hold the timeout counter |
| stat_clr_i | input | 1 | Clear the trip status |
| nmi_o | output | 1 | Non-maskable interrupt |
| stat_cause_o | output | 2 | 0 none, 1 mismatch, 2 timeout |
| stat_idx_o | output | IDX_W | Step index at the trip |

## Verification
The hardest situations to reach from the ports are the exact edge of a timeout window and a freeze in the middle of a step. To reach them, the bench drives each signature a counted number of edges after the step starts. It presents one signature on the last allowed edge and checks that it is accepted, and it checks that the trip comes on the T-th edge and not one edge earlier. A step's count is also split around a long freeze, so that the signature is accepted only because the frozen cycles were not counted. The bench also shows that the table is locked while running. It rewrites entry 0 and the count in the middle of a walk, then completes a full lap and its wrap using the original values.

// File: rtl/sswd_pkg.sv
package sswd_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_MISMATCH = 2'd1,
    CAUSE_TIMEOUT  = 2'd2
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TRIP = 2'd2
  } state_e;
endpackage

// File: rtl/sswd_table.sv
module sswd_table #(
  parameter int DEPTH = 16,
  parameter int SIG_W = 16,
  parameter int TMO_W = 16,
  parameter int NRD   = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [SIG_W-1:0] wsig_i,
  input  logic [TMO_W-1:0] wtmo_i,
  input  logic [IDX_W-1:0] raddr_i [NRD],
  output logic [SIG_W-1:0] rsig_o  [NRD],
  output logic [TMO_W-1:0] rtmo_o  [NRD]
);
  logic [SIG_W-1:0] sig_q [DEPTH];
  logic [TMO_W-1:0] tmo_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sig_q[e] <= '0;
        tmo_q[e] <= '0;
      end else if (we_i && waddr_i == IDX_W'(e)) begin
        sig_q[e] <= wsig_i;
        tmo_q[e] <= wtmo_i;
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rsig_o[r] = sig_q[raddr_i[r]];
    assign rtmo_o[r] = tmo_q[raddr_i[r]];
  end
endmodule

// File: rtl/sswd_timer.sv
module sswd_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMO_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  // one count left: an idle cycle now expires the step
  assign last_o = (cnt_q <= TMO_W'(1));
endmodule

// File: rtl/sswd_seq.sv
module sswd_seq
  import sswd_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SIG_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             len_we_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             sig_valid_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic             freeze_i,
  input  logic             clr_i,
  input  logic [SIG_W-1:0] cur_sig_i,
  input  logic             last_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] ld_idx_o,
  output logic             load_o,
  output logic             dec_o,
  output logic             cfg_open_o,
  output logic             run_o,
  output logic [CNT_W-1:0] len_o,
  output cause_e           cause_o,
  output logic [IDX_W-1:0] fail_idx_o
);
  state_e           state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, nxt_idx;
  logic [CNT_W-1:0] len_q;
  cause_e           cause_q, cause_d;
  logic [IDX_W-1:0] fail_q, fail_d;

  assign nxt_idx = ({1'b0, idx_q} == CNT_W'(len_q - 1'b1)) ? '0 : idx_q + 1'b1;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    cause_d  = cause_q;
    fail_d   = fail_q;
    load_o   = 1'b0;
    dec_o    = 1'b0;
    ld_idx_o = nxt_idx;
    unique case (state_q)
      ST_IDLE: begin
        ld_idx_o = '0;
        if (en_i && len_q != '0) begin
          state_d = ST_RUN;
          idx_d   = '0;
          load_o  = 1'b1;
        end
      end
      ST_RUN: begin
        if (!en_i) begin
          state_d = ST_IDLE;
        end else if (sig_valid_i) begin
          if (sig_i == cur_sig_i) begin
            idx_d  = nxt_idx;
            load_o = 1'b1;
          end else begin
            state_d = ST_TRIP;
            cause_d = CAUSE_MISMATCH;
            fail_d  = idx_q;
          end
        end else if (!freeze_i) begin
          if (last_i) begin
            state_d = ST_TRIP;
            cause_d = CAUSE_TIMEOUT;
            fail_d  = idx_q;
          end else begin
            dec_o = 1'b1;
          end
        end
      end
      ST_TRIP: begin
        if (clr_i) begin
          state_d = ST_IDLE;
          cause_d = CAUSE_NONE;
          fail_d  = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cause_q <= CAUSE_NONE;
      fail_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cause_q <= cause_d;
      fail_q  <= fail_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) len_q <= '0;
    else if (len_we_i && state_q == ST_IDLE)
      len_q <= (len_i > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : len_i;
  end

  assign cfg_open_o = (state_q == ST_IDLE);
  assign run_o      = (state_q == ST_RUN);
  assign idx_o      = idx_q;
  assign len_o      = len_q;
  assign cause_o    = cause_q;
  assign fail_idx_o = fail_q;
endmodule

// File: rtl/sig_seq_wdog.sv
module sig_seq_wdog
  import sswd_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SIG_W = 16,
  parameter int TMO_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [SIG_W-1:0] cfg_sig_i,
  input  logic [TMO_W-1:0] cfg_tmo_i,
  input  logic             cfg_len_we_i,
  input  logic [CNT_W-1:0] cfg_len_i,
  input  logic             cfg_en_i,
  input  logic             sig_valid_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic             freeze_i,
  input  logic             stat_clr_i,
  output logic             nmi_o,
  output logic [1:0]       stat_cause_o,
  output logic [IDX_W-1:0] stat_idx_o
);
  logic [IDX_W-1:0] step_idx, ld_idx;
  logic [IDX_W-1:0] raddr [2];
  logic [SIG_W-1:0] rsig  [2];
  logic [TMO_W-1:0] rtmo  [2];
  logic             load, dec, last, cfg_open, run;
  logic [CNT_W-1:0] len;
  cause_e           cause;

  assign raddr[0] = step_idx;
  assign raddr[1] = ld_idx;

  sswd_table #(.DEPTH(DEPTH), .SIG_W(SIG_W), .TMO_W(TMO_W), .NRD(2)) i_table (
    .clk_i, .rst_ni,
    .we_i    (cfg_we_i && cfg_open),
    .waddr_i (cfg_idx_i),
    .wsig_i  (cfg_sig_i),
    .wtmo_i  (cfg_tmo_i),
    .raddr_i (raddr),
    .rsig_o  (rsig),
    .rtmo_o  (rtmo)
  );

  sswd_timer #(.TMO_W(TMO_W)) i_timer (
    .clk_i, .rst_ni,
    .load_i     (load),
    .load_val_i (rtmo[1]),
    .dec_i      (dec),
    .last_o     (last)
  );

  sswd_seq #(.DEPTH(DEPTH), .SIG_W(SIG_W)) i_seq (
    .clk_i, .rst_ni,
    .en_i        (cfg_en_i),
    .len_we_i    (cfg_len_we_i),
    .len_i       (cfg_len_i),
    .sig_valid_i (sig_valid_i),
    .sig_i       (sig_i),
    .freeze_i    (freeze_i),
    .clr_i       (stat_clr_i),
    .cur_sig_i   (rsig[0]),
    .last_i      (last),
    .idx_o       (step_idx),
    .ld_idx_o    (ld_idx),
    .load_o      (load),
    .dec_o       (dec),
    .cfg_open_o  (cfg_open),
    .run_o       (run),
    .len_o       (len),
    .cause_o     (cause),
    .fail_idx_o  (stat_idx_o)
  );

  assign stat_cause_o = cause;
  assign nmi_o        = (cause != CAUSE_NONE);
endmodule

// File: rtl/sig_seq_wdog_chk.sv
module sig_seq_wdog_chk #(
  parameter int SIG_W = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_en_i,
  input logic             sig_valid_i,
  input logic [SIG_W-1:0] sig_i,
  input logic             freeze_i,
  input logic             stat_clr_i,
  input logic             nmi_o,
  input logic [1:0]       stat_cause_o,
  input logic             run,
  input logic [SIG_W-1:0] exp_sig,
  input logic [IDX_W-1:0] step_idx,
  input logic [CNT_W-1:0] len
);
  // R5
  mismatch_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && cfg_en_i && sig_valid_i && sig_i != exp_sig |=> nmi_o && stat_cause_o == 2'd1);

  // R7
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && cfg_en_i && freeze_i && !sig_valid_i |=> !nmi_o);

  // R8
  nmi_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o && !stat_clr_i |=> nmi_o);

  // R8
  nmi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o && stat_clr_i |=> !nmi_o && stat_cause_o == 2'd0);

  // R4
  timeout_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) && stat_cause_o == 2'd2 |-> $past(!sig_valid_i && !freeze_i));

  // R3
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> {1'b0, step_idx} < len);

  // R9
  disable_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !cfg_en_i |=> !nmi_o);
endmodule

bind sig_seq_wdog sig_seq_wdog_chk #(.SIG_W(SIG_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_en_i     (cfg_en_i),
  .sig_valid_i  (sig_valid_i),
  .sig_i        (sig_i),
  .freeze_i     (freeze_i),
  .stat_clr_i   (stat_clr_i),
  .nmi_o        (nmi_o),
  .stat_cause_o (stat_cause_o),
  .run          (run),
  .exp_sig      (rsig[0]),
  .step_idx     (step_idx),
  .len          (len)
);

// File: tb/test_sig_seq_wdog.sv
module test_sig_seq_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we = 1'b0, cfg_len_we = 1'b0, cfg_en = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [15:0]      cfg_sig = '0, cfg_tmo = '0, sig = '0;
  logic [CNT_W-1:0] cfg_len = '0;
  logic             sig_valid = 1'b0, freeze = 1'b0, clr = 1'b0;
  logic             nmi;
  logic [1:0]       cause;
  logic [IDX_W-1:0] fidx;
  int               n_chk = 0, n_bad = 0;
  bit               done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sig_seq_wdog i_sig_seq_wdog (
    .clk_i(clk), .rst_ni,
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_sig_i(cfg_sig), .cfg_tmo_i(cfg_tmo),
    .cfg_len_we_i(cfg_len_we), .cfg_len_i(cfg_len), .cfg_en_i(cfg_en),
    .sig_valid_i(sig_valid), .sig_i(sig), .freeze_i(freeze), .stat_clr_i(clr),
    .nmi_o(nmi), .stat_cause_o(cause), .stat_idx_o(fidx)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_entry(int i, int s, int t);
    cfg_we = 1'b1; cfg_idx = IDX_W'(i); cfg_sig = 16'(s); cfg_tmo = 16'(t);
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic put_len(int n);
    cfg_len_we = 1'b1; cfg_len = CNT_W'(n);
    tick(1);
    cfg_len_we = 1'b0;
  endtask

  // idle edges, then the signature on the next edge
  task automatic send(int s, int wait_edges);
    tick(wait_edges);
    sig_valid = 1'b1; sig = 16'(s);
    tick(1);
    sig_valid = 1'b0;
  endtask

  task automatic start();
    cfg_en = 1'b1;
    tick(1);
  endtask

  task automatic tidy();
    cfg_en = 1'b0; freeze = 1'b0; clr = 1'b1;
    tick(1);
    clr = 1'b0;
    tick(1);
  endtask

  task automatic load_std();
    put_entry(0, 16'h1111, 5);
    put_entry(1, 16'h2222, 6);
    put_entry(2, 16'h3333, 4);
    put_len(3);
  endtask

  task automatic t_reset();
    check("R10 nmi", nmi, 0);
    check("R10 cause", cause, 0);
    check("R10 idx", fidx, 0);
  endtask

  task automatic t_idle();
    load_std();
    put_len(0);
    start();
    send(16'hdead, 2);
    send(16'h1111, 30);
    check("R1 no walk with count 0", nmi, 0);
    cfg_en = 1'b0;
    put_len(3);
    send(16'hbeef, 3);
    check("R1 idle with enable low", nmi, 0);
    tidy();
  endtask

  task automatic t_pass();
    start();
    send(16'h1111, 4);
    check("R3 accepted on last edge", nmi, 0);
    send(16'h2222, 0);
    send(16'h3333, 3);
    check("R3 first lap", nmi, 0);
    send(16'h1111, 1);
    check("R6 wrap to entry 0", nmi, 0);
    send(16'h2222, 5);
    send(16'h3333, 0);
    check("R3 second lap", nmi, 0);
    tick(4);
    check("R6 entry 0 timeout not yet", nmi, 0);
    tick(1);
    check("R6 wrapped timeout nmi", nmi, 1);
    check("R6 wrapped timeout cause", cause, 2);
    check("R6 wrapped timeout idx", fidx, 0);
    tidy();
  endtask

  task automatic t_timeout();
    start();
    send(16'h1111, 0);
    tick(5);
    check("R4 one edge before expiry", nmi, 0);
    tick(1);
    check("R4 nmi at T-th edge", nmi, 1);
    check("R4 cause", cause, 2);
    check("R4 idx", fidx, 1);
    cfg_en = 1'b0;
    tick(10);
    check("R8 nmi sticky", nmi, 1);
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    check("R8 cleared nmi", nmi, 0);
    check("R8 cleared cause", cause, 0);
    tidy();
  endtask

  task automatic t_mismatch();
    start();
    send(16'h1111, 0);
    send(16'hbeef, 1);
    check("R5 wrong value nmi", nmi, 1);
    check("R5 wrong value cause", cause, 1);
    check("R5 wrong value idx", fidx, 1);
    tidy();
    start();
    send(16'h3333, 0);
    check("R5 out of order cause", cause, 1);
    check("R5 out of order idx", fidx, 0);
    tidy();
  endtask

  task automatic t_freeze();
    start();
    tick(2);
    freeze = 1'b1;
    tick(20);
    check("R7 frozen no timeout", nmi, 0);
    freeze = 1'b0;
    tick(2);
    check("R7 count resumed", nmi, 0);
    send(16'h1111, 0);
    check("R7 accepted after freeze", nmi, 0);
    freeze = 1'b1;
    send(16'h9999, 3);
    check("R7 compare while frozen cause", cause, 1);
    check("R7 compare while frozen idx", fidx, 1);
    tidy();
  endtask

  task automatic t_locked();
    start();
    put_entry(0, 16'haaaa, 2);
    put_len(1);
    send(16'h1111, 0);
    send(16'h2222, 0);
    send(16'h3333, 0);
    send(16'h1111, 3);
    check("R2 writes while running ignored", nmi, 0);
    check("R2 cause", cause, 0);
    tidy();
  endtask

  task automatic t_disable();
    start();
    tick(2);
    cfg_en = 1'b0;
    tick(20);
    check("R9 disabled no trip", nmi, 0);
    start();
    send(16'h1111, 0);
    check("R9 restart from entry 0", nmi, 0);
    tidy();
  endtask

  task automatic t_clr_restart();
    start();
    tick(5);
    check("R8 trip with enable high", nmi, 1);
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    check("R8 clear with enable high", nmi, 0);
    tick(1);
    send(16'h1111, 0);
    check("R8 restarted at entry 0", nmi, 0);
    tick(6);
    check("R8 restarted step 1 timeout", cause, 2);
    check("R8 restarted step 1 idx", fidx, 1);
    tidy();
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    t_reset();
    t_idle();
    t_pass();
    t_timeout();
    t_mismatch();
    t_freeze();
    t_locked();
    t_disable();
    t_clr_restart();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule